// File: doc/BRIEF.md
# Ethernet PHY Status LED Controller

This block drives four active-high LED pins of an Ethernet PHY from the PHY's status signals. The status signals are link state, link speed, power-down, energy-efficient mode, auto-negotiation, analog self-test and cable diagnostics. Three single-cycle activity strobes also feed it: transmit, receive and collision. Each LED has a constant-on condition, a fast-blink condition and a slow-blink condition, each a 4-bit condition code. Each LED also has an activity mask. While an activity event that the mask selects is being stretched, the LED is forced dark. This gives a visible flicker on an otherwise lit LED.

Two shared square-wave generators divide the system clock (`CLK_HZ`) down to the blink rates. Each generator's rate can be set to 2, 4, 8 or 16 Hz. A small synchronous register port holds ten 8-bit configuration registers. The global register carries the two rate codes. The second global register is storage only. Each LED then has a high register (constant-on and fast-blink codes) and a low register (slow-blink code and activity mask).

Top module: `phy_led_ctrl`

## Requirements
- R1: Ten registers sit at consecutive addresses from `BASE_ADDR` (default 0x1E0), in this order: global, second global, then for LED0..LED3 a high register followed by a low register. In the global register, fast rate = bits 7:6, slow rate = bits 5:4, and bits 2:0 are stored only. In the second global register, bits 6:4 and 2:0 are stored only. In a high register, constant-on code = bits 7:4 and fast-blink code = bits 3:0. In a low register, slow-blink code = bits 7:4 and activity mask = bits 3:0.
- R2: After reset the registers read 0x00C5, 0x0067, 0x0070, 0x0003, 0x0020, 0x0000, 0x0040, 0x0000, 0x0040, 0x0020, in address order.
- R3: Reserved bits are ignored on write and read as zero: bits 15:8 everywhere, bit 3 of both global registers, bit 7 of the second global register, and mask bit 3. A read outside the ten addresses returns 0, and a write there changes nothing.
- R4: The condition codes are: 0 none; 1 = 10 Mb/s; 2 = 100 Mb/s; 3 = 10 or 100; 4 = 1000; 5 = 10 or 1000; 6 = 100 or 1000; 7 = any speed. Link-speed codes are met only while `link_up` is high. Speed input encoding: 0 = 10, 1 = 100, 2 = 1000, 3 = no speed. The remaining codes are 8 powered down, 9 energy-efficient mode, 10 auto-negotiation, 11 self-test and 12 cable diagnostics.
- R5: Codes 13, 14 and 15 are never met.
- R6: With no blink or activity in effect, an LED is lit exactly when its constant-on condition is met.
- R7: Rate code r gives a blink half-period of (CLK_HZ/4) >> r clock cycles, with 50% duty.
- R8: A rate change takes effect at the next half-period boundary: the half-period in progress finishes at the old length.
- R9: Priority is activity, then fast blink, then slow blink, then constant-on.
- R10: A strobe whose mask bit is set (bit0 tx, bit1 rx, bit2 collision) forces the LED off for STRETCH_CYC+1 cycles after the edge that samples it, where STRETCH_CYC = CLK_HZ*STRETCH_MS/1000. A strobe whose mask bit is clear has no effect.
- R11: Mask bit 3 selects no event.
- R12: LED outputs are registered: a status change sampled at a clock edge shows on the pins after that same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | ADDR_W | Register address |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data for `addr` (combinational) |
| link_up | input | 1 | Link is up |
| speed | input | 2 | Link speed: 0=10, 1=100, 2=1000, 3=none |
| pdown | input | 1 | Device powered down |
| eee_mode | input | 1 | Energy-efficient mode active |
| aneg_run | input | 1 | Auto-negotiation running |
| abist_run | input | 1 | Analog self-test running |
| cdiag_run | input | 1 | Cable diagnostics running |
| tx_act | input | 1 | Transmit activity strobe |
| rx_act | input | 1 | Receive activity strobe |
| col_act | input | 1 | Collision strobe |
| led | output | 4 | Active-high LED outputs |

## Verification
A wrong divider count shows up at the LED pins as a blink half-period of the wrong length, starting from the first toggle after the fault. A generator that ignores the half-period boundary shows up as a half-period whose length changes in the middle of the interval during which a rate was written. A wrong stretch counter shows up as a dark gap that is too short or too long, which can be measured to the exact cycle. A mis-decoded register field shows up on the LED one cycle after the status it should follow, or as a wrong value on readback.

// File: rtl/phy_led_ctrl.sv
module phy_led_ctrl #(
  parameter int unsigned CLK_HZ     = 25_000_000,
  parameter int unsigned STRETCH_MS = 40,
  parameter int unsigned ADDR_W     = 9,
  parameter int unsigned BASE_ADDR  = 'h1E0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [15:0]       wdata,
  output logic [15:0]       rdata,
  input  logic              link_up,
  input  logic [1:0]        speed,
  input  logic              pdown,
  input  logic              eee_mode,
  input  logic              aneg_run,
  input  logic              abist_run,
  input  logic              cdiag_run,
  input  logic              tx_act,
  input  logic              rx_act,
  input  logic              col_act,
  output logic [3:0]        led
);

  localparam int NLED        = 4;
  localparam int NREG        = 2 + 2 * NLED;
  localparam int HALF0       = CLK_HZ / 4;
  localparam int CW          = $clog2(HALF0 + 1);
  localparam int STRETCH_CYC = int'((longint'(CLK_HZ) * longint'(STRETCH_MS)) / 1000);
  localparam int SW          = $clog2(STRETCH_CYC + 1);
  localparam logic [31:0] RST_HI = 32'h40_40_20_70;
  localparam logic [31:0] RST_LO = 32'h20_00_00_03;

  logic [ADDR_W-1:0] off;
  logic              in_rng;
  assign off    = addr - ADDR_W'(BASE_ADDR);
  assign in_rng = (addr >= ADDR_W'(BASE_ADDR)) && (off < ADDR_W'(NREG));

  logic [1:0] fast_r, slow_r;
  logic [2:0] g_inv, g_scan, g_cbl;
  logic [3:0] con [NLED];
  logic [3:0] fbl [NLED];
  logic [3:0] sbl [NLED];
  logic [2:0] pmask [NLED];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fast_r <= 2'd3;
      slow_r <= 2'd0;
      g_inv  <= 3'd5;
      g_scan <= 3'd6;
      g_cbl  <= 3'd7;
      for (int i = 0; i < NLED; i++) begin
        con[i]   <= RST_HI[8*i+4 +: 4];
        fbl[i]   <= RST_HI[8*i   +: 4];
        sbl[i]   <= RST_LO[8*i+4 +: 4];
        pmask[i] <= RST_LO[8*i   +: 3];
      end
    end else if (wr_en && in_rng) begin
      if (off == 0) begin
        fast_r <= wdata[7:6];
        slow_r <= wdata[5:4];
        g_inv  <= wdata[2:0];
      end
      if (off == 1) begin
        g_scan <= wdata[6:4];
        g_cbl  <= wdata[2:0];
      end
      for (int i = 0; i < NLED; i++) begin
        if (off == ADDR_W'(2 + 2*i)) begin
          con[i] <= wdata[7:4];
          fbl[i] <= wdata[3:0];
        end
        if (off == ADDR_W'(3 + 2*i)) begin
          sbl[i]   <= wdata[7:4];
          pmask[i] <= wdata[2:0];
        end
      end
    end
  end

  always_comb begin
    rdata = '0;
    if (in_rng) begin
      if (off == 0) rdata[7:0] = {fast_r, slow_r, 1'b0, g_inv};
      if (off == 1) rdata[7:0] = {1'b0, g_scan, 1'b0, g_cbl};
      for (int i = 0; i < NLED; i++) begin
        if (off == ADDR_W'(2 + 2*i)) rdata[7:0] = {con[i], fbl[i]};
        if (off == ADDR_W'(3 + 2*i)) rdata[7:0] = {sbl[i], 1'b0, pmask[i]};
      end
    end
  end

  function automatic logic [CW-1:0] half_of(input logic [1:0] r);
    half_of = CW'(HALF0 >> r);
  endfunction

  logic [CW-1:0] bcnt [2];
  logic [1:0]    wave;

  for (genvar g = 0; g < 2; g++) begin : g_blink
    logic [1:0] rsel;
    assign rsel = (g == 0) ? fast_r : slow_r;
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        bcnt[g] <= half_of((g == 0) ? 2'd3 : 2'd0) - CW'(1);
        wave[g] <= 1'b0;
      end else if (bcnt[g] == '0) begin
        bcnt[g] <= half_of(rsel) - CW'(1);
        wave[g] <= ~wave[g];
      end else begin
        bcnt[g] <= bcnt[g] - CW'(1);
      end
    end

    AST_WAVE_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(wave[g]) |-> $past(bcnt[g]) == '0); // R7
    AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      bcnt[g] < CW'(HALF0)); // R8
  end

  function automatic logic cmet(input logic [3:0] c, input logic lu, input logic [1:0] sp,
                                input logic [4:0] st);
    logic [2:0] spd_hot;
    spd_hot = (!lu) ? 3'b000 : (sp == 2'd0) ? 3'b001 : (sp == 2'd1) ? 3'b010 :
              (sp == 2'd2) ? 3'b100 : 3'b000;
    if (c[3] == 1'b0) cmet = |(c[2:0] & spd_hot);
    else if (c[2:0] <= 3'd4) cmet = st[c[2:0]];
    else cmet = 1'b0;
  endfunction

  logic [4:0] st;
  logic [2:0] act;
  assign st  = {cdiag_run, abist_run, aneg_run, eee_mode, pdown};
  assign act = {col_act, rx_act, tx_act};

  logic [SW-1:0] scnt [NLED];
  logic [NLED-1:0] hit;

  for (genvar i = 0; i < NLED; i++) begin : g_led
    assign hit[i] = |(pmask[i] & act);

    always_ff @(posedge clk) begin
      if (!rst_n) scnt[i] <= '0;
      else if (hit[i]) scnt[i] <= SW'(STRETCH_CYC);
      else if (scnt[i] != '0) scnt[i] <= scnt[i] - SW'(1);
    end

    always_ff @(posedge clk) begin
      if (!rst_n) led[i] <= 1'b0;
      else if (hit[i] || scnt[i] != '0) led[i] <= 1'b0;
      else if (cmet(fbl[i], link_up, speed, st)) led[i] <= wave[0];
      else if (cmet(sbl[i], link_up, speed, st)) led[i] <= wave[1];
      else led[i] <= cmet(con[i], link_up, speed, st);
    end

    AST_PULSE_DARK: assert property (@(posedge clk) disable iff (!rst_n)
      hit[i] |=> !led[i]); // R10
    AST_STRETCH_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      scnt[i] <= SW'(STRETCH_CYC)); // R10
  end

  AST_OOR_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !in_rng) |=> ($stable(fast_r) && $stable(slow_r) && $stable(g_scan))); // R3

endmodule

// File: tb/tb_phy_led_ctrl.sv
module tb_phy_led_ctrl;
  localparam int CLK_HZ = 320;
  localparam int SMS    = 50;
  localparam int NSTR   = CLK_HZ * SMS / 1000;
  localparam int BASE   = 'h1E0;

  logic clk = 0, rst_n = 0, wr_en = 0;
  logic [8:0] addr = 0;
  logic [15:0] wdata = 0, rdata;
  logic link_up = 0, pdown = 0, eee_mode = 0, aneg_run = 0, abist_run = 0, cdiag_run = 0;
  logic [1:0] speed = 0;
  logic tx_act = 0, rx_act = 0, col_act = 0;
  logic [3:0] led;
  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  phy_led_ctrl #(.CLK_HZ(CLK_HZ), .STRETCH_MS(SMS)) dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata),
    .link_up(link_up), .speed(speed), .pdown(pdown), .eee_mode(eee_mode),
    .aneg_run(aneg_run), .abist_run(abist_run), .cdiag_run(cdiag_run),
    .tx_act(tx_act), .rx_act(rx_act), .col_act(col_act), .led(led));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk); wr_en = 1; addr = 9'(a); wdata = 16'(d);
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(input int a, output int d);
    @(negedge clk); addr = 9'(a); #1 d = int'(rdata);
  endtask

  function automatic bit exp_cond(input int c);
    bit s10, s100, s1000;
    s10 = link_up && speed == 0; s100 = link_up && speed == 1; s1000 = link_up && speed == 2;
    case (c)
      1: return s10;           2: return s100;
      3: return s10 || s100;   4: return s1000;
      5: return s10 || s1000;  6: return s100 || s1000;
      7: return s10 || s100 || s1000;
      8: return pdown;   9: return eee_mode; 10: return aneg_run;
      11: return abist_run; 12: return cdiag_run;
      default: return 0;
    endcase
  endfunction

  task automatic wait_toggle(input int i, output int n);
    logic prev;
    prev = led[i]; n = 0;
    do begin @(negedge clk); n++; end while (led[i] == prev && n < 1000);
  endtask

  task automatic quiet_all();
    for (int i = 0; i < 4; i++) begin wr(BASE + 2 + 2*i, 0); wr(BASE + 3 + 2*i, 0); end
  endtask

  initial begin
    #(20ns * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int d, n;
    int rstv [10] = '{'h00C5, 'h0067, 'h0070, 'h0003, 'h0020, 'h0000, 'h0040, 'h0000, 'h0040, 'h0020};
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(led == 4'b0000, "R2 leds after reset", led, 0);
    for (int a = 0; a < 10; a++) begin
      rd(BASE + a, d);
      chk(d == rstv[a], $sformatf("R2 R1 reset value reg %0d", a), d, rstv[a]);
    end

    // R3 reserved bits and out-of-range
    for (int a = 0; a < 10; a++) begin
      int exp;
      wr(BASE + a, 'hFFFF);
      rd(BASE + a, d);
      exp = (a == 0) ? 'hF7 : (a == 1) ? 'h77 : (a % 2 == 0) ? 'hFF : 'hF7;
      chk(d == exp, "R3 reserved bits read zero", d, exp);
    end
    wr(BASE + 10, 'h0000);
    wr(BASE - 1, 'h0000);
    rd(BASE + 10, d); chk(d == 0, "R3 out-of-range read", d, 0);
    rd(BASE, d); chk(d == 'hF7, "R3 out-of-range write ignored", d, 'hF7);
    quiet_all();

    // R12 registered output
    wr(BASE + 2, 'h70);
    @(negedge clk); link_up = 0; speed = 1;
    @(negedge clk); link_up = 1; #1;
    chk(led[0] == 0, "R12 not before edge", led[0], 0);
    @(negedge clk);
    chk(led[0] == 1, "R12 one edge later", led[0], 1);

    // R4 R5 R6 random conditions
    for (int it = 0; it < 60; it++) begin
      int cc [4];
      for (int i = 0; i < 4; i++) begin
        cc[i] = (it < 4) ? 13 + (i % 3) : int'($urandom_range(0, 15));
        wr(BASE + 2 + 2*i, cc[i] << 4);
      end
      @(negedge clk);
      link_up = 1'($urandom); speed = 2'($urandom); pdown = 1'($urandom);
      eee_mode = 1'($urandom); aneg_run = 1'($urandom); abist_run = 1'($urandom);
      cdiag_run = 1'($urandom);
      if (it < 4) {link_up, pdown, eee_mode, aneg_run, abist_run, cdiag_run} = '1;
      @(negedge clk);
      for (int i = 0; i < 4; i++)
        chk(led[i] == exp_cond(cc[i]), $sformatf("R4 R5 R6 led%0d code %0d", i, cc[i]),
            led[i], exp_cond(cc[i]));
    end
    {pdown, eee_mode, aneg_run, abist_run, cdiag_run} = '0;
    link_up = 1; speed = 1;
    quiet_all();

    // R7 fast and slow half-periods
    wr(BASE + 2, 'h07);
    for (int r = 0; r < 4; r++) begin
      wr(BASE, r << 6);
      wait_toggle(0, n); wait_toggle(0, n); wait_toggle(0, n);
      wait_toggle(0, n);
      chk(n == (CLK_HZ/4) >> r, $sformatf("R7 fast rate %0d", r), n, (CLK_HZ/4) >> r);
    end
    wr(BASE + 2, 'h00); wr(BASE + 3, 'h70);
    wr(BASE, 2 << 4);
    wait_toggle(0, n); wait_toggle(0, n); wait_toggle(0, n);
    chk(n == 20, "R7 slow rate 2", n, 20);
    wait_toggle(0, n);
    chk(n == 20, "R7 slow duty", n, 20);

    // R8 rate change at boundary
    wr(BASE + 3, 'h00); wr(BASE + 2, 'h07);
    wr(BASE, 0);
    wait_toggle(0, n); wait_toggle(0, n); wait_toggle(0, n);
    fork
      begin repeat (5) @(negedge clk); wr(BASE, 3 << 6); end
      wait_toggle(0, n);
    join
    chk(n == 80, "R8 old half finishes", n, 80);
    wait_toggle(0, n);
    chk(n == 10, "R8 new half applies", n, 10);

    // R9 priority
    wr(BASE, (3 << 6) | (1 << 4));
    wr(BASE + 4, 'h70); wr(BASE + 5, 'h70);
    wait_toggle(1, n); wait_toggle(1, n); wait_toggle(1, n);
    chk(n == 40, "R9 slow over constant", n, 40);
    wr(BASE + 4, 'h77);
    wait_toggle(1, n); wait_toggle(1, n); wait_toggle(1, n);
    chk(n == 10, "R9 fast over slow", n, 10);
    quiet_all();

    // R10 stretch, R9 activity priority
    wr(BASE + 6, 'h70); wr(BASE + 7, 'h01);
    @(negedge clk); tx_act = 1;
    @(negedge clk); tx_act = 0;
    for (int k = 0; k <= NSTR; k++) begin
      chk(led[2] == 0, $sformatf("R10 R9 dark cycle %0d", k), led[2], 0);
      if (k < NSTR) @(negedge clk);
    end
    @(negedge clk);
    chk(led[2] == 1, "R10 relit after stretch", led[2], 1);
    rx_act = 1; col_act = 1;
    @(negedge clk); rx_act = 0; col_act = 0;
    chk(led[2] == 1, "R10 unmasked strobe no effect", led[2], 1);
    wr(BASE + 7, 'h04);
    col_act = 1; @(negedge clk); col_act = 0;
    chk(led[2] == 0, "R10 collision mask", led[2], 0);
    repeat (NSTR + 2) @(negedge clk);
    wr(BASE + 7, 'h08);
    tx_act = 1; rx_act = 1; col_act = 1;
    @(negedge clk); tx_act = 0; rx_act = 0; col_act = 0;
    chk(led[2] == 1, "R11 mask bit3 no effect", led[2], 1);
    rd(BASE + 7, d);
    chk(d == 0, "R11 mask bit3 reads zero", d, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule